// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside an instruction sequencer and decides which interrupt, if any, is taken when the current instruction ends. It watches five request lines. The first is a non-maskable line. Three fixed-vector lines can each be masked. The last is an external-device line whose target comes from an opcode that the device supplies. The block qualifies the lines with a global enable flag and a three-bit mask register, and resolves them in a fixed priority order. It then hands the sequencer a 16-bit call address through a request/acknowledge pair.

For the three fixed lines and the non-maskable line, the address is computed inside the block. For the external-device line, the block first drives a one-cycle acknowledge pulse and captures the byte on the opcode input during that pulse. If that byte is a restart opcode, the block decodes it into its call address. The sequencer drives commands to set and clear the global enable and to write the mask register. Pushing the return address is left to the sequencer.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, take_req_o and ext_ack_o are 0, the global enable is clear and all three mask bits are set, so no maskable line is taken until software enables it.
- R2: The fixed call addresses are 0x0024 for nmi_i (src_o=0), 0x003C for hi_edge_i (src_o=1), 0x0034 for mid_lvl_i (src_o=2) and 0x002C for low_lvl_i (src_o=3); the external line reports src_o=4.
- R3: When several qualified requests are present at once, nmi_i wins, then hi_edge_i, then mid_lvl_i, then low_lvl_i, and ext_lvl_i comes last.
- R4: nmi_i is taken whether or not the global enable is set and whatever the mask register holds.
- R5: ext_lvl_i is taken only while the global enable is set, and the mask register has no effect on it.
- R6: hi_edge_i, mid_lvl_i and low_lvl_i are taken only while the global enable is set and their mask bit is 0; mask_wdata_i bit 2 masks hi_edge_i, bit 1 masks mid_lvl_i and bit 0 masks low_lvl_i, and a 1 masks the line.
- R7: Accepting any line other than nmi_i clears the global enable. en_set_i and en_clr_i act on the next cycle, and en_clr_i wins when both are high in the same cycle.
- R8: A rising edge on hi_edge_i is held in a latch, even while the line is masked or disabled, until that line is accepted; the input going low again does not clear the latch.
- R9: mid_lvl_i, low_lvl_i and ext_lvl_i are level inputs and are not stored; a request that goes low before a boundary is not taken.
- R10: Requests are accepted only in a cycle where boundary_i is high and no earlier interrupt is still in progress.
- R11: Accepting ext_lvl_i drives ext_ack_o high for exactly one cycle, starting the cycle after acceptance; opcode_i is sampled in that cycle, and take_req_o rises in the next cycle.
- R12: For a byte of the form 11nnn111, restart_o is 1 and vec_o is nnn times 8 (0xE7 gives 0x0020). For any other byte, restart_o is 0 and vec_o is 0. In both cases insn_o carries the captured byte.
- R13: take_req_o, vec_o and src_o hold steady until take_ack_i is seen high, and take_req_o is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request, level |
| hi_edge_i | input | 1 | Edge-triggered maskable request |
| mid_lvl_i | input | 1 | Level maskable request, middle priority |
| low_lvl_i | input | 1 | Level maskable request, low priority |
| ext_lvl_i | input | 1 | External-device request, level |
| boundary_i | input | 1 | Instruction boundary from the sequencer |
| en_set_i | input | 1 | Set the global enable |
| en_clr_i | input | 1 | Clear the global enable |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 3 | New mask value |
| take_ack_i | input | 1 | Sequencer has taken the offered interrupt |
| opcode_i | input | 8 | Byte supplied by the device during ext_ack_o |
| take_req_o | output | 1 | An interrupt is being offered |
| vec_o | output | 16 | Call address of the offered interrupt |
| src_o | output | 3 | Source code of the offered interrupt |
| ext_ack_o | output | 1 | One-cycle acknowledge to the external device |
| insn_o | output | 8 | Byte captured during the acknowledge |
| restart_o | output | 1 | Captured byte was a restart opcode |

## Verification
The assertions check several properties on every cycle. A granted maskable line must really be enabled and unmasked. nmi_i must always win the grant. The acknowledge pulse must last one cycle and be followed by an offer. An offer must hold until it is taken. The enable must drop after a maskable acceptance. The edge latch must not clear by itself. Any history-dependent behaviour can only be shown by the bench's scenarios against its cycle model: the reset masks gating lines, the latch surviving a released input, level requests vanishing unserved, the priority order across one crowded boundary, and the restart decoding of specific bytes.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int SRC_N     = 5;
    localparam int SRC_W     = 3;
    localparam int MASK_N    = 3;
    localparam int OP_W      = 8;
    localparam int FIX_BASE  = 'h24;
    localparam int FIX_STEP  = 8;
    localparam int RST_SHIFT = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NMI = 3'd0,
        SRC_HI  = 3'd1,
        SRC_MID = 3'd2,
        SRC_LOW = 3'd3,
        SRC_EXT = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_OFFER = 2'd2
    } st_e;

    // slot in the fixed vector table, spaced FIX_STEP apart
    function automatic int fixed_slot(input src_e s);
        case (s)
            SRC_LOW: return 1;
            SRC_MID: return 2;
            SRC_HI:  return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int fixed_vec(input src_e s);
        return FIX_BASE + FIX_STEP * fixed_slot(s);
    endfunction

    function automatic logic is_restart(input logic [OP_W-1:0] b);
        return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
    endfunction

    function automatic int restart_vec(input logic [OP_W-1:0] b);
        return int'(b[5:3]) << RST_SHIFT;
    endfunction

endpackage

// File: rtl/irqv_edge_hold.sv
module irqv_edge_hold #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic [W-1:0] clr,
    output logic [W-1:0] held
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;

    assign rise = din & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            held   <= '0;
        end else begin
            prev_q <= din;
            // a new edge in the clearing cycle survives
            held   <= rise | (held & ~clr);
        end
    end

    AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (held[0] && !clr[0]) |=> held[0]); // R8

endmodule

// File: rtl/irqv_gate_regs.sv
module irqv_gate_regs
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [MASK_N-1:0] wdata_i,
    input  logic              accept_i,
    output logic              ie_o,
    output logic [MASK_N-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_o   <= 1'b0;
            mask_o <= '1;
        end else begin
            if (accept_i)   ie_o <= 1'b0;
            else if (clr_i) ie_o <= 1'b0;
            else if (set_i) ie_o <= 1'b1;
            if (we_i) mask_o <= wdata_i;
        end
    end

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
(
    input  logic [SRC_N-1:0]  raw_i,
    input  logic              ie_i,
    input  logic [MASK_N-1:0] mask_i,
    output logic [SRC_N-1:0]  grant_o,
    output src_e              code_o,
    output logic              any_o
);
    logic [SRC_N-1:0] qual;

    // index equals source code; lower index wins
    for (genvar i = 0; i < SRC_N; i++) begin : g_qual
        if (i == 0) begin : g_nmi
            assign qual[i] = raw_i[i];
        end else if (i <= MASK_N) begin : g_masked
            assign qual[i] = raw_i[i] & ie_i & ~mask_i[MASK_N - i];
        end else begin : g_plain
            assign qual[i] = raw_i[i] & ie_i;
        end
    end

    assign grant_o = qual & (~qual + 1'b1);
    assign any_o   = |qual;

    always_comb begin
        code_o = SRC_NMI;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (qual[i]) code_o = src_e'(SRC_W'(i));
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_i,
    input  logic              hi_edge_i,
    input  logic              mid_lvl_i,
    input  logic              low_lvl_i,
    input  logic              ext_lvl_i,
    input  logic              boundary_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              mask_we_i,
    input  logic [MASK_N-1:0] mask_wdata_i,
    input  logic              take_ack_i,
    input  logic [OP_W-1:0]   opcode_i,
    output logic              take_req_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic [SRC_W-1:0]  src_o,
    output logic              ext_ack_o,
    output logic [OP_W-1:0]   insn_o,
    output logic              restart_o
);
    st_e               st;
    src_e              src_q;
    logic              hi_held;
    logic              hi_clear;
    logic              ie;
    logic [MASK_N-1:0] mask;
    logic [SRC_N-1:0]  raw;
    logic [SRC_N-1:0]  grant;
    src_e              win;
    logic              any;
    logic              accept;
    logic              take_masked;

    irqv_edge_hold #(.W(1)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (hi_edge_i),
        .clr  (hi_clear),
        .held (hi_held)
    );

    irqv_gate_regs u_gate (
        .clk      (clk),
        .rst      (rst),
        .set_i    (en_set_i),
        .clr_i    (en_clr_i),
        .we_i     (mask_we_i),
        .wdata_i  (mask_wdata_i),
        .accept_i (take_masked),
        .ie_o     (ie),
        .mask_o   (mask)
    );

    assign raw = {ext_lvl_i, low_lvl_i, mid_lvl_i, hi_held, nmi_i};

    irqv_prio u_prio (
        .raw_i   (raw),
        .ie_i    (ie),
        .mask_i  (mask),
        .grant_o (grant),
        .code_o  (win),
        .any_o   (any)
    );

    assign accept      = (st == ST_IDLE) && boundary_i && any;
    assign take_masked = accept && (win != SRC_NMI);
    assign hi_clear    = accept && (win == SRC_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            src_q     <= SRC_NMI;
            vec_o     <= '0;
            insn_o    <= '0;
            restart_o <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        src_q <= win;
                        if (win == SRC_EXT) begin
                            st <= ST_ACK;
                        end else begin
                            st        <= ST_OFFER;
                            vec_o     <= ADDR_W'(fixed_vec(win));
                            insn_o    <= '0;
                            restart_o <= 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    insn_o    <= opcode_i;
                    restart_o <= is_restart(opcode_i);
                    vec_o     <= is_restart(opcode_i) ? ADDR_W'(restart_vec(opcode_i)) : '0;
                    st        <= ST_OFFER;
                end
                ST_OFFER: begin
                    if (take_ack_i) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign take_req_o = (st == ST_OFFER);
    assign ext_ack_o  = (st == ST_ACK);
    assign src_o      = src_q;

    AST_NMI_ALWAYS_WINS: assert property (@(posedge clk) disable iff (rst)
        nmi_i |-> grant[SRC_NMI]); // R4
    AST_MID_GATED: assert property (@(posedge clk) disable iff (rst)
        grant[SRC_MID] |-> (ie && !mask[1])); // R6
    AST_HI_GATED: assert property (@(posedge clk) disable iff (rst)
        grant[SRC_HI] |-> (ie && !mask[2] && hi_held)); // R6
    AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst)
        grant[SRC_EXT] |-> ie); // R5
    AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        take_masked |=> !ie); // R7
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ext_ack_o |=> !ext_ack_o); // R11
    AST_ACK_THEN_OFFER: assert property (@(posedge clk) disable iff (rst)
        ext_ack_o |=> take_req_o); // R11
    AST_OFFER_STEADY: assert property (@(posedge clk) disable iff (rst)
        (take_req_o && !take_ack_i) |=> (take_req_o && $stable(vec_o) && $stable(src_o))); // R13
    AST_OFFER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (take_req_o && take_ack_i) |=> !take_req_o); // R13
    AST_BOUNDARY_START: assert property (@(posedge clk) disable iff (rst)
        (ext_ack_o || (take_req_o && $past(st) == ST_IDLE)) |-> $past(boundary_i)); // R10
    AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (take_req_o && src_o == SRC_NMI) |-> (vec_o == ADDR_W'(FIX_BASE))); // R2

endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       nmi = 0, hi_edge = 0, mid_lvl = 0, low_lvl = 0, ext_lvl = 0;
    logic       bnd = 0, en_set = 0, en_clr = 0, mwe = 0, tack = 0;
    logic [2:0] mwd = 3'b000;
    logic [7:0] opc = 8'h00;

    logic        take_req_o, ext_ack_o, restart_o;
    logic [15:0] vec_o;
    logic [2:0]  src_o;
    logic [7:0]  insn_o;

    int n_chk = 0, n_fail = 0, cyc = 0;

    irq_vector_ctrl u0 (
        .clk(clk), .rst(rst), .nmi_i(nmi), .hi_edge_i(hi_edge), .mid_lvl_i(mid_lvl),
        .low_lvl_i(low_lvl), .ext_lvl_i(ext_lvl), .boundary_i(bnd), .en_set_i(en_set),
        .en_clr_i(en_clr), .mask_we_i(mwe), .mask_wdata_i(mwd), .take_ack_i(tack),
        .opcode_i(opc), .take_req_o(take_req_o), .vec_o(vec_o), .src_o(src_o),
        .ext_ack_o(ext_ack_o), .insn_o(insn_o), .restart_o(restart_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference
    bit       m_ie, m_held, m_prev, m_rop;
    bit [2:0] m_mask;
    int       m_st, m_src, m_vec, m_ins;

    function automatic int fixed_addr(input int s);
        case (s)
            0: return 'h24;
            1: return 'h3C;
            2: return 'h34;
            default: return 'h2C;
        endcase
    endfunction

    always @(posedge clk) begin
        bit [4:0] q;
        int  w;
        bit  acc, rise;
        if (rst) begin
            m_ie = 0; m_mask = 3'b111; m_held = 0; m_prev = 0; m_st = 0;
            m_src = 0; m_vec = 0; m_ins = 0; m_rop = 0;
        end else begin
            q[0] = nmi;
            q[1] = m_held && m_ie && !m_mask[2];
            q[2] = mid_lvl && m_ie && !m_mask[1];
            q[3] = low_lvl && m_ie && !m_mask[0];
            q[4] = ext_lvl && m_ie;
            w = -1;
            for (int i = 4; i >= 0; i--) if (q[i]) w = i;
            acc  = (m_st == 0) && bnd && (w >= 0);
            rise = hi_edge && !m_prev;
            case (m_st)
                0: if (acc) begin
                    m_src = w;
                    if (w == 4) m_st = 1;
                    else begin m_st = 2; m_vec = fixed_addr(w); m_ins = 0; m_rop = 0; end
                end
                1: begin
                    m_ins = opc;
                    m_rop = (opc[7:6] == 2'b11) && (opc[2:0] == 3'b111);
                    m_vec = m_rop ? int'(opc[5:3]) * 8 : 0;
                    m_st  = 2;
                end
                default: if (tack) m_st = 0;
            endcase
            if (acc && w != 0) m_ie = 0;
            else if (en_clr)   m_ie = 0;
            else if (en_set)   m_ie = 1;
            if (mwe) m_mask = mwd;
            if (rise) m_held = 1;
            else if (acc && w == 1) m_held = 0;
            m_prev = hi_edge;
        end
        #2;
        chk(take_req_o === (m_st == 2), "R13 take_req_o", int'(take_req_o), int'(m_st == 2));
        chk(ext_ack_o === (m_st == 1), "R11 ext_ack_o", int'(ext_ack_o), int'(m_st == 1));
        if (m_st == 2) begin
            chk(int'(src_o) == m_src, "R3 src_o", int'(src_o), m_src);
            chk(int'(vec_o) == m_vec, m_src == 4 ? "R12 vec_o" : "R2 vec_o", int'(vec_o), m_vec);
            if (m_src == 4) begin
                chk(int'(insn_o) == m_ins, "R12 insn_o", int'(insn_o), m_ins);
                chk(restart_o === m_rop, "R12 restart_o", int'(restart_o), int'(m_rop));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog all actual=%0d expected=<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic cycle(); @(negedge clk); endtask

    task automatic set_en();
        en_set = 1; cycle(); en_set = 0;
    endtask

    task automatic clr_en();
        en_clr = 1; cycle(); en_clr = 0;
    endtask

    task automatic wmask(input logic [2:0] v);
        mwe = 1; mwd = v; cycle(); mwe = 0;
    endtask

    task automatic pulse_hi();
        hi_edge = 1; cycle(); hi_edge = 0; cycle();
    endtask

    task automatic serve(input int ev, input bit want_ack, input string tag);
        bit seen = 0;
        bnd = 1; cycle(); bnd = 0;
        for (int k = 0; k < 4 && !take_req_o; k++) begin
            if (ext_ack_o) seen = 1;
            cycle();
        end
        chk(take_req_o === 1'b1, tag, int'(take_req_o), 1);
        chk(int'(vec_o) == ev, tag, int'(vec_o), ev);
        if (want_ack) chk(seen, "R11 ack pulse before offer", int'(seen), 1);
        tack = 1; cycle(); tack = 0;
    endtask

    task automatic expect_none(input string tag);
        bnd = 1; cycle(); bnd = 0;
        for (int k = 0; k < 3; k++) begin
            chk(!take_req_o && !ext_ack_o, tag, int'(take_req_o | ext_ack_o), 0);
            cycle();
        end
    endtask

    initial begin
        repeat (3) cycle();
        rst = 0;
        cycle();
        chk(!take_req_o && !ext_ack_o, "R1 outputs idle after reset", int'(take_req_o | ext_ack_o), 0);

        mid_lvl = 1; low_lvl = 1;
        expect_none("R1 enable clear after reset");
        set_en();
        expect_none("R1 masks set after reset");
        wmask(3'b110);
        serve('h2C, 0, "R6 unmasked low line taken");
        expect_none("R7 enable cleared by acceptance");

        set_en(); wmask(3'b000);
        serve('h34, 0, "R3 mid over low");
        mid_lvl = 0; low_lvl = 0;

        pulse_hi();
        expect_none("R8 edge held but disabled");
        set_en();
        serve('h3C, 0, "R8 latched edge served after release");
        set_en();
        expect_none("R8 latch cleared by acceptance");

        wmask(3'b100); pulse_hi();
        expect_none("R6 masked edge line");
        wmask(3'b000);
        serve('h3C, 0, "R8 edge kept while masked");

        wmask(3'b111); clr_en(); nmi = 1;
        serve('h24, 0, "R4 nmi ignores enable and masks");

        wmask(3'b000); set_en(); pulse_hi();
        mid_lvl = 1; low_lvl = 1; ext_lvl = 1; opc = 8'hE7;
        serve('h24, 0, "R3 nmi first");
        nmi = 0;
        serve('h3C, 0, "R3 edge line second, enable kept after nmi");
        set_en();
        serve('h34, 0, "R3 mid third");
        mid_lvl = 0; set_en();
        serve('h2C, 0, "R3 low fourth");
        low_lvl = 0; set_en();
        serve('h20, 1, "R12 restart E7 gives 0020");
        set_en(); opc = 8'hFF;
        serve('h38, 1, "R12 restart FF gives 0038");
        set_en(); opc = 8'h4F;
        serve('h00, 1, "R12 non-restart byte");
        chk(insn_o == 8'h4F && !restart_o, "R12 captured byte held", int'(insn_o), 'h4F);

        clr_en(); opc = 8'hC7;
        expect_none("R5 external line needs enable");
        wmask(3'b111); set_en();
        serve('h00, 1, "R5 external line ignores masks");
        ext_lvl = 0;

        wmask(3'b000); set_en();
        mid_lvl = 1; cycle(); mid_lvl = 0;
        expect_none("R9 dropped level not remembered");

        mid_lvl = 1;
        repeat (5) begin
            chk(!take_req_o, "R10 no acceptance without boundary", int'(take_req_o), 0);
            cycle();
        end
        serve('h34, 0, "R10 taken at boundary");
        mid_lvl = 0;

        en_set = 1; en_clr = 1; cycle(); en_set = 0; en_clr = 0;
        mid_lvl = 1;
        expect_none("R7 clear wins over set");
        mid_lvl = 0;

        repeat (3) cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule